// File: doc/BRIEF.md
# Edge and Center-Aligned PWM Channel

This block is a single pulse-width modulation channel with its own 16-bit timebase. A mode input picks the timebase shape: an up-counter that returns to zero after reaching the modulus (edge-aligned), or a counter that climbs to the modulus and then descends back to zero (center-aligned, symmetric pulses). An invert input selects whether the pulse is active-high or active-low.

Software loads the duty value and the modulus through an 8-bit write port as low/high byte pairs. The modulus takes effect once both of its bytes have arrived. The duty value is held in a staging buffer and moves into the active compare register only when both bytes have been written and the counter is about to return to zero. Each new duty therefore starts on a period boundary and never produces a truncated or stretched pulse. Besides the PWM pin, the block raises an overflow indication once per period.

Top module: `pwm_dual_align`

## Requirements
- R1: After synchronous reset the counter, the active duty and both staging buffers are zero, the modulus is 0xFFFF, `ovf` is low and `pwm_out` equals `invert`.
- R2: A write with `wr_addr` 0 or 1 stores the low or high duty byte, and 2 or 3 stores the low or high modulus byte. A new modulus applies only after both of its bytes have been written, in either order. A single byte leaves the period unchanged.
- R3: In edge mode (`center_mode`=0) the counter runs 0,1,…,M and wraps, so the period is M+1 cycles. `ovf` is high for exactly the one cycle in which the counter holds M. With a duty D in 1..M and `invert`=0, the output is low in that cycle and high in the next.
- R4: In edge mode with `invert`=0 the output is high while the counter is below D. Each period has min(D, M+1) high cycles, so D=0 gives 0% and D>M gives 100%.
- R5: `invert`=1 inverts the output in both modes, so the high-cycle count per period becomes period minus the non-inverted count.
- R6: In center mode (`center_mode`=1, M in 1..0x7FFF) the counter climbs 0..M and then descends M-1..1, giving a period of 2·M cycles. `ovf` is high for one cycle per period, at the top (counter = M).
- R7: In center mode with `invert`=0, a duty D with bit 15 set, or D=0, gives 0%. A positive D>M gives 100%. For 0<D<M there are 2·D high cycles centered on counter value 0, and D=M gives 2·M−1.
- R8: A new duty value becomes active only after both duty bytes have been written (in either order) and at the edge where the counter returns to zero. A lone byte, or a pair completed mid-period, leaves the current period's waveform untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select: 0 duty low, 1 duty high, 2 modulus low, 3 modulus high |
| wr_data | input | 8 | Byte to write |
| center_mode | input | 1 | 0 edge-aligned, 1 center-aligned |
| invert | input | 1 | 1 makes the pulse active-low |
| pwm_out | output | 1 | PWM pin |
| ovf | output | 1 | One cycle per period at the counter's terminal value |

## Verification
`pwm_out` and `ovf` are decoded combinationally from registered state, so they follow the counter in the cycle it holds a value. A modulus applies one clock after its second byte. A duty applies from the first counter-zero cycle after its pair completes. The bench changes inputs on falling edges and samples there. Before it measures any configuration, it waits several full periods so that both commits have certainly happened. Each duty measurement counts high cycles and `ovf` pulses over a window of exactly one period, which gives the same result wherever the window starts. Checks on the order of events (pulse start after `ovf`, mid-period duty writes) first synchronise to an `ovf` cycle, where the counter is known to hold M, and then count cycles from there.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SEL_DUTY_LO = 2'd0,
        SEL_DUTY_HI = 2'd1,
        SEL_MOD_LO  = 2'd2,
        SEL_MOD_HI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
        logic  hi_seen;
        logic  lo_seen;
    } pair_buf_t;

    localparam pair_buf_t PAIR_EMPTY = '{hi: '0, lo: '0, hi_seen: 1'b0, lo_seen: 1'b0};

    function automatic pair_buf_t pair_write(pair_buf_t b, logic wr_lo, logic wr_hi, byte_t d);
        pair_buf_t r = b;
        if (wr_lo) begin
            r.lo      = d;
            r.lo_seen = 1'b1;
        end
        if (wr_hi) begin
            r.hi      = d;
            r.hi_seen = 1'b1;
        end
        return r;
    endfunction

    function automatic logic pair_full(pair_buf_t b);
        return b.lo_seen && b.hi_seen;
    endfunction

    function automatic logic edge_level(cnt_t c, cnt_t d);
        return c < d;
    endfunction

    function automatic logic center_level(cnt_t c, cnt_t d, logic rising);
        if (d[CNT_W-1]) return 1'b0;
        return rising ? (c < d) : (c <= d);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter cnt_t RESET_MOD = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  [1:0] wr_addr,
    input  byte_t wr_data,
    input  logic  wrap_i,
    output cnt_t  duty_o,
    output cnt_t  mod_o,
    output logic  mod_load_o
);

    pair_buf_t duty_buf_q, mod_buf_q;
    pair_buf_t duty_buf_d, mod_buf_d;
    cnt_t      duty_q, mod_q;
    logic      duty_commit;

    logic wr_dlo, wr_dhi, wr_mlo, wr_mhi;

    assign wr_dlo = wr_en && (wr_addr == SEL_DUTY_LO);
    assign wr_dhi = wr_en && (wr_addr == SEL_DUTY_HI);
    assign wr_mlo = wr_en && (wr_addr == SEL_MOD_LO);
    assign wr_mhi = wr_en && (wr_addr == SEL_MOD_HI);

    assign duty_commit = pair_full(duty_buf_q) && wrap_i;
    assign mod_load_o  = pair_full(mod_buf_q);

    always_comb begin
        duty_buf_d = duty_buf_q;
        if (duty_commit) begin
            duty_buf_d.hi_seen = 1'b0;
            duty_buf_d.lo_seen = 1'b0;
        end
        duty_buf_d = pair_write(duty_buf_d, wr_dlo, wr_dhi, wr_data);

        mod_buf_d = mod_buf_q;
        if (mod_load_o) begin
            mod_buf_d.hi_seen = 1'b0;
            mod_buf_d.lo_seen = 1'b0;
        end
        mod_buf_d = pair_write(mod_buf_d, wr_mlo, wr_mhi, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_buf_q <= PAIR_EMPTY;
            mod_buf_q  <= PAIR_EMPTY;
            duty_q     <= '0;
            mod_q      <= RESET_MOD;
        end else begin
            duty_buf_q <= duty_buf_d;
            mod_buf_q  <= mod_buf_d;
            if (duty_commit) duty_q <= {duty_buf_q.hi, duty_buf_q.lo};
            if (mod_load_o)  mod_q  <= {mod_buf_q.hi, mod_buf_q.lo};
        end
    end

    assign duty_o = duty_q;
    assign mod_o  = mod_q;

    // R8: the active duty only moves at a counter-zero boundary
    a_r8_commit_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (duty_q != $past(duty_q)) |-> $past(wrap_i));

    // R2: the modulus only moves after a complete byte pair
    a_r2_mod_needs_pair: assert property (@(posedge clk) disable iff (rst)
        (!mod_buf_q.hi_seen || !mod_buf_q.lo_seen) |=> $stable(mod_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic center_i,
    input  cnt_t mod_i,
    input  logic mod_load_i,
    output cnt_t cnt_o,
    output logic up_o,
    output logic ovf_o,
    output logic wrap_o
);

    cnt_t cnt_q, cnt_nxt;
    logic up_q, up_nxt;
    logic mod_zero;

    assign mod_zero = (mod_i == '0);

    always_comb begin
        cnt_nxt = cnt_q;
        up_nxt  = up_q;
        if (!center_i) begin
            up_nxt  = 1'b1;
            cnt_nxt = (cnt_q >= mod_i) ? '0 : cnt_q + 1'b1;
        end else if (mod_zero) begin
            cnt_nxt = '0;
            up_nxt  = 1'b1;
        end else if (up_q && (cnt_q < mod_i)) begin
            cnt_nxt = cnt_q + 1'b1;
        end else if (cnt_q == '0) begin
            cnt_nxt = cnt_t'(1);
            up_nxt  = 1'b1;
        end else begin
            cnt_nxt = cnt_q - 1'b1;
            up_nxt  = (cnt_q == cnt_t'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            up_q  <= up_nxt;
        end
    end

    assign cnt_o  = cnt_q;
    assign up_o   = up_q;
    assign ovf_o  = up_q && (cnt_q >= mod_i) && !(center_i && mod_zero);
    assign wrap_o = (cnt_nxt == '0);

    // R3: an edge-mode overflow cycle is always followed by counter zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (!center_i && ovf_o) |=> (cnt_q == '0));

    // R6: the descending half steps down by exactly one
    a_r6_down_step: assert property (@(posedge clk) disable iff (rst)
        (center_i && !up_q && !mod_zero && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: once inside the range, the center counter stays inside it
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        (center_i && !mod_zero && (cnt_q <= mod_i) && !mod_load_i) |=> (cnt_q <= mod_i));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt_i,
    input  logic up_i,
    input  cnt_t duty_i,
    input  logic center_i,
    input  logic invert_i,
    output logic pwm_o
);

    logic raw;

    always_comb begin
        if (center_i) raw = center_level(cnt_i, duty_i, up_i);
        else          raw = edge_level(cnt_i, duty_i);
    end

    assign pwm_o = raw ^ invert_i;

    // R7: a duty with its sign bit set never raises the center-mode pulse
    a_r7_neg_duty_low: assert property (@(posedge clk) disable iff (rst)
        (center_i && duty_i[CNT_W-1]) |-> (pwm_o == invert_i));

    // R4: a zero duty never raises the edge-mode pulse
    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (!center_i && (duty_i == '0)) |-> (pwm_o == invert_i));

endmodule

// File: rtl/pwm_dual_align.sv
module pwm_dual_align
    import pwm_pkg::*;
#(
    parameter logic [15:0] RESET_MOD = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       center_mode,
    input  logic       invert,
    output logic       pwm_out,
    output logic       ovf
);

    cnt_t duty, modulus, cnt;
    logic up, wrap, mod_load;

    pwm_regs #(.RESET_MOD(RESET_MOD)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wrap_i     (wrap),
        .duty_o     (duty),
        .mod_o      (modulus),
        .mod_load_o (mod_load)
    );

    pwm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .center_i   (center_mode),
        .mod_i      (modulus),
        .mod_load_i (mod_load),
        .cnt_o      (cnt),
        .up_o       (up),
        .ovf_o      (ovf),
        .wrap_o     (wrap)
    );

    pwm_compare u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cnt_i    (cnt),
        .up_i     (up),
        .duty_i   (duty),
        .center_i (center_mode),
        .invert_i (invert),
        .pwm_o    (pwm_out)
    );

    // R1: outputs right after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> (!ovf && (pwm_out == invert)));

endmodule

// File: tb/pwm_dual_align_tb.sv
module pwm_dual_align_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       center_mode = 1'b0;
    logic       invert = 1'b0;
    logic       pwm_out, ovf;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pwm_dual_align u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .center_mode(center_mode), .invert(invert), .pwm_out(pwm_out), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_duty(input int v);
        wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
    endtask

    task automatic set_mod(input int v);
        wr(2'd2, v[7:0]); wr(2'd3, v[15:8]);
    endtask

    task automatic measure(input int len, output int hi, output int ov);
        hi = 0; ov = 0;
        for (int i = 0; i < len; i++) begin
            hi += int'(pwm_out);
            ov += int'(ovf);
            @(negedge clk);
        end
    endtask

    task automatic wait_ovf();
        for (int i = 0; i < 1000 && !ovf; i++) @(negedge clk);
    endtask

    function automatic int exp_high(input bit cen, input int m, input int d);
        if (!cen) return (d > m) ? m + 1 : d;
        if (d[15] || d == 0) return 0;
        if (d > m) return 2 * m;
        if (d == m) return 2 * m - 1;
        return 2 * d;
    endfunction

    task automatic run_cfg(input bit cen, input bit inv, input int m, input int d);
        int per, hi, ov, e;
        center_mode = cen; invert = inv;
        set_mod(m); set_duty(d);
        repeat (6 * m + 10) @(negedge clk);
        per = cen ? 2 * m : m + 1;
        measure(per, hi, ov);
        e = exp_high(cen, m, d);
        if (inv) e = per - e;
        if (!cen && !inv) chk(hi == e, "R4 edge high count", hi, e);
        else if (cen && !inv) chk(hi == e, "R7 center high count", hi, e);
        else chk(hi == e, "R5 inverted high count", hi, e);
        if (cen) chk(ov == 1, "R6 one ovf per center period", ov, 1);
        else     chk(ov == 1, "R3 one ovf per edge period", ov, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int hi, ov;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
        chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
        invert = 1'b1; #1;
        chk(pwm_out == 1'b1, "R1 pwm equals invert", int'(pwm_out), 1);
        invert = 1'b0;
        @(negedge clk);

        // R4 R5 R3: edge sweep
        for (int m = 3; m <= 5; m += 2)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d <= m + 2; d++)
                    run_cfg(1'b0, p[0], m, d);

        // R7 R5 R6: center sweep including a sign-bit duty
        for (int m = 3; m <= 4; m++)
            for (int p = 0; p < 2; p++) begin
                for (int d = 0; d <= m + 2; d++) run_cfg(1'b1, p[0], m, d);
                run_cfg(1'b1, p[0], m, 32'h8002);
            end

        // R3: pulse starts on the cycle after ovf
        run_cfg(1'b0, 1'b0, 7, 3);
        wait_ovf();
        chk(pwm_out == 1'b0, "R3 low in ovf cycle", int'(pwm_out), 0);
        @(negedge clk);
        chk(pwm_out == 1'b1, "R3 high after ovf", int'(pwm_out), 1);

        // R7: pulse centered on zero (low at top, high at bottom)
        run_cfg(1'b1, 1'b0, 6, 2);
        wait_ovf();
        chk(pwm_out == 1'b0, "R7 low at top", int'(pwm_out), 0);
        repeat (6) @(negedge clk);
        chk(pwm_out == 1'b1, "R7 high at bottom", int'(pwm_out), 1);

        // R8: lone low byte has no effect
        run_cfg(1'b0, 1'b0, 9, 2);
        wr(2'd0, 8'd7);
        repeat (30) @(negedge clk);
        measure(10, hi, ov);
        chk(hi == 2, "R8 lone byte ignored", hi, 2);

        // R8: pair completed mid-period waits for the wrap
        wait_ovf();
        @(negedge clk);
        @(negedge clk);
        wr(2'd0, 8'd6);
        wr(2'd1, 8'd0);
        chk(pwm_out == 1'b0, "R8 mid-period keeps old duty", int'(pwm_out), 0);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R8 mid-period keeps old duty", int'(pwm_out), 0);
        wait_ovf();
        @(negedge clk);
        measure(10, hi, ov);
        chk(hi == 6, "R8 new duty next period", hi, 6);

        // R8: high byte first also commits
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd4);
        repeat (30) @(negedge clk);
        measure(10, hi, ov);
        chk(hi == 4, "R8 hi-first order", hi, 4);

        // R2: lone modulus byte keeps the period
        wr(2'd2, 8'd4);
        repeat (30) @(negedge clk);
        measure(30, hi, ov);
        chk(ov == 3, "R2 lone mod byte ignored", ov, 3);
        wr(2'd3, 8'd0);
        repeat (30) @(negedge clk);
        measure(30, hi, ov);
        chk(ov == 6, "R2 new modulus after pair", ov, 6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule